// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block is the receive side of a bus-master network controller. It moves the bytes of received frames out of a receive FIFO and into buffers in host memory. Software builds a chain of descriptors in memory. Each descriptor holds three 32-bit words: a link to the next descriptor, a command/status word, and a buffer address. Software hands a descriptor to the engine by clearing its ownership flag. It then loads the address of the first descriptor into the engine's list pointer.

The engine fetches the current descriptor and checks the ownership flag. If the engine owns the buffer, it copies FIFO data into the buffer as one or more fragments. It then writes the command/status word back and follows the link. A frame larger than its buffer continues in the next descriptor, and the chaining flag is set in each descriptor that is not the last of its frame. A refresh path re-reads the current descriptor only to pick up its link. This lets the engine resume along a chain that software has extended after the engine reached a null link.

A separate detector raises a receive-overflow interrupt when the FIFO is pushed while it is full. This happens when the engine has run out of descriptors in the middle of a frame.

Top module: `rxdesc_dma`

## Requirements
- R1: After reset the engine is idle: `mem_req`, `fifo_take` and `irq_rx_ovr` are low.
- R2: When the engine is idle, `rx_en` is high and `refresh` is low, it issues a descriptor read (`mem_op` 0) at the current descriptor address. `mem_rdata` returns the link in bits [31:0], the command/status word in [63:32] and the buffer address in [95:64].
- R3: A `ptr_load` pulse sets the current descriptor address only while the engine is idle; at any other time it has no effect.
- R4: If a descriptor read returns command/status bit 31 (ownership) set, the engine makes no data or status write for it and returns to idle. While `rx_en` is high, it then reads the same descriptor again.
- R5: Each fragment is a data write (`mem_op` 1) whose length is the smallest of three values: the bytes left in the buffer, `fifo_avail`, and MAX_FRAG (64 by default). Its address is the buffer address plus the bytes already written to that buffer. A `fifo_take` pulse reports the length when the write completes. Buffer sizes (command/status bits [11:0]) are multiples of 32.
- R6: A frame ends when a fragment takes all of `fifo_avail` while `fifo_eop` is high. The status write (`mem_op` 2, address = descriptor + 4) then sets bit 31, clears bit 30 and puts `fifo_status` into bits [23:16]. Bits [11:0] hold the bytes written to that buffer.
- R7: When a buffer fills before its frame ends, the status write sets bits 31 and 30 and clears bits [23:16]. Bits [11:0] hold the buffer size, and the frame continues in the next descriptor.
- R8: After a status write, a non-zero link makes the link the current descriptor and starts a descriptor read there. A zero link returns the engine to idle with the current descriptor unchanged.
- R9: When the engine is idle with `rx_en` and `refresh` high, it issues a link read (`mem_op` 3) of the current descriptor. It then follows that link as in R8, with no ownership check on the refreshed descriptor.
- R10: A request holds `mem_req`, `mem_op` and `mem_addr` steady until its one-cycle `mem_done`. Only one request is outstanding.
- R11: `irq_rx_ovr` pulses high for one cycle in the cycle after a cycle in which `fifo_push` and `fifo_full` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| refresh | input | 1 | Resume by re-reading the current descriptor's link |
| ptr_load | input | 1 | Load the list pointer (honoured only when idle) |
| ptr_value | input | AW | New list pointer value |
| fifo_avail | input | FCW | Bytes of the current frame present in the FIFO |
| fifo_eop | input | 1 | The FIFO holds the rest of the current frame |
| fifo_status | input | SW | Receive status of the current frame |
| fifo_take | output | 1 | A fragment has been written out of the FIFO |
| fifo_take_len | output | SZW | Byte count of that fragment |
| fifo_full | input | 1 | FIFO is full |
| fifo_push | input | 1 | Receiver writes into the FIFO |
| mem_req | output | 1 | Memory request |
| mem_op | output | 2 | 0 descriptor read, 1 data write, 2 status write, 3 link read |
| mem_addr | output | AW | Request address |
| mem_len | output | SZW | Byte count of a data write |
| mem_wdata | output | 32 | Command/status word for a status write |
| mem_rdata | input | 96 | Descriptor words returned with `mem_done` |
| mem_done | input | 1 | One-cycle completion of the request |
| irq_rx_ovr | output | 1 | Receive-overflow interrupt pulse |

## Verification
The hardest situation to reach is a frame that spans several buffers and whose data arrives in the FIFO in pieces. The fragment length then depends in turn on the FIFO level, on the bytes left in the buffer, and on the burst cap. The stimulus uses a chain of three descriptors of different sizes. It releases a 100-byte frame into the FIFO in two pieces, holding the second piece until the first fragment has been taken. A second frame of 150 bytes, fed in through the refresh path, exercises the burst cap. The memory model keeps each status write it receives, so a return to the final descriptor reads ownership set. This shows that the engine stops there and writes nothing more.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DRD,
      ST_FBLK,
      ST_FWR,
      ST_DWR,
      ST_ADV,
      ST_REFR
   } rx_state_e;

   localparam int WORD_W    = 32;
   localparam int DESC_W    = 3 * WORD_W;
   localparam int OWN_BIT   = 31;
   localparam int MORE_BIT  = 30;
   localparam int STAT_LSB  = 16;

   localparam logic [1:0] OP_DESC_RD = 2'd0;
   localparam logic [1:0] OP_DATA_WR = 2'd1;
   localparam logic [1:0] OP_STAT_WR = 2'd2;
   localparam logic [1:0] OP_LINK_RD = 2'd3;

endpackage

// File: rtl/rxdesc_ovf.sv
module rxdesc_ovf (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_full,
   input  logic fifo_push,
   output logic irq_rx_ovr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_rx_ovr <= 1'b0;
      else        irq_rx_ovr <= fifo_full & fifo_push;
   end

   // R11
   ovr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && fifo_push) |=> irq_rx_ovr);

endmodule

// File: rtl/rxdesc_fsm.sv
module rxdesc_fsm
   import rxdesc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rx_en,
   input  logic      refresh,
   input  logic      mem_done,
   input  logic      rd_own,
   input  logic      link_nz,
   input  logic      avail_nz,
   input  logic      frag_last,
   input  logic      frag_fills,
   output rx_state_e state,
   output logic      mem_req,
   output logic      fifo_take
);

   rx_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (rx_en) nxt = refresh ? ST_REFR : ST_DRD;
         ST_DRD:  if (mem_done) nxt = rd_own ? ST_IDLE : ST_FBLK;
         ST_FBLK: if (avail_nz) nxt = ST_FWR;
         ST_FWR:  if (mem_done) nxt = (frag_last || frag_fills) ? ST_DWR : ST_FBLK;
         ST_DWR:  if (mem_done) nxt = ST_ADV;
         ST_ADV:  nxt = link_nz ? ST_DRD : ST_IDLE;
         ST_REFR: if (mem_done) nxt = ST_ADV;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign mem_req   = (state == ST_DRD) || (state == ST_FWR) ||
                      (state == ST_DWR) || (state == ST_REFR);
   assign fifo_take = (state == ST_FWR) && mem_done;

   // R4
   own_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRD && mem_done && rd_own) |=> state == ST_IDLE);

endmodule

// File: rtl/rxdesc_ctx.sv
module rxdesc_ctx
   import rxdesc_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SW       = 8,
   parameter int SZW      = 12,
   parameter int FCW      = 12,
   parameter int MAX_FRAG = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  rx_state_e          state,
   input  logic               mem_done,
   input  logic [DESC_W-1:0]  mem_rdata,
   input  logic               ptr_load,
   input  logic [AW-1:0]      ptr_value,
   input  logic [FCW-1:0]     fifo_avail,
   input  logic               fifo_eop,
   input  logic [SW-1:0]      fifo_status,
   output logic [1:0]         mem_op,
   output logic [AW-1:0]      mem_addr,
   output logic [SZW-1:0]     mem_len,
   output logic [WORD_W-1:0]  mem_wdata,
   output logic               rd_own,
   output logic               link_nz,
   output logic               avail_nz,
   output logic               frag_last,
   output logic               frag_fills,
   output logic [SZW-1:0]     frag_len
);

   localparam int CW = (FCW > SZW) ? FCW : SZW;

   logic [AW-1:0]  cur_ptr, link_q, buf_addr;
   logic [SZW-1:0] remaining, written;
   logic [SW-1:0]  stat_q;
   logic           pkt_end;

   logic [AW-1:0]  rd_link, rd_buf;
   logic [SZW-1:0] rd_size;
   logic [CW-1:0]  avail_x, rem_x, cap_x, len_x;
   logic           unused_rd;

   assign rd_link   = mem_rdata[AW-1:0];
   assign rd_buf    = mem_rdata[2*WORD_W +: AW];
   assign rd_size   = mem_rdata[WORD_W +: SZW];
   assign rd_own    = mem_rdata[WORD_W + OWN_BIT];
   assign unused_rd = ^mem_rdata;

   assign avail_x  = CW'(fifo_avail);
   assign rem_x    = CW'(remaining);
   assign avail_nz = (fifo_avail != '0);

   generate
      if (MAX_FRAG == 0) begin : g_nocap
         assign cap_x = rem_x;
      end else begin : g_cap
         assign cap_x = (rem_x > CW'(MAX_FRAG)) ? CW'(MAX_FRAG) : rem_x;
      end
   endgenerate

   assign len_x = (avail_x < cap_x) ? avail_x : cap_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_ptr   <= '0;
         link_q    <= '0;
         buf_addr  <= '0;
         remaining <= '0;
         written   <= '0;
         frag_len  <= '0;
         frag_last <= 1'b0;
         stat_q    <= '0;
         pkt_end   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (ptr_load) cur_ptr <= ptr_value;
            ST_DRD: if (mem_done) begin
               link_q    <= rd_link;
               buf_addr  <= rd_buf;
               remaining <= rd_size;
               written   <= '0;
               pkt_end   <= 1'b0;
            end
            ST_REFR: if (mem_done) link_q <= rd_link;
            ST_FBLK: if (avail_nz) begin
               frag_len  <= len_x[SZW-1:0];
               frag_last <= fifo_eop && (len_x == avail_x);
            end
            ST_FWR: if (mem_done) begin
               buf_addr  <= buf_addr + AW'(frag_len);
               remaining <= remaining - frag_len;
               written   <= written + frag_len;
               if (frag_last) begin
                  pkt_end <= 1'b1;
                  stat_q  <= fifo_status;
               end
            end
            ST_ADV: if (link_nz) cur_ptr <= link_q;
            default: ;
         endcase
      end
   end

   assign link_nz    = (link_q != '0);
   assign frag_fills = (frag_len == remaining);

   always_comb begin
      mem_op    = OP_DESC_RD;
      mem_addr  = cur_ptr;
      mem_len   = '0;
      mem_wdata = '0;
      unique case (state)
         ST_REFR: mem_op = OP_LINK_RD;
         ST_FWR: begin
            mem_op   = OP_DATA_WR;
            mem_addr = buf_addr;
            mem_len  = frag_len;
         end
         ST_DWR: begin
            mem_op              = OP_STAT_WR;
            mem_addr            = cur_ptr + AW'(4);
            mem_wdata[OWN_BIT]  = 1'b1;
            mem_wdata[MORE_BIT] = ~pkt_end;
            if (pkt_end) mem_wdata[STAT_LSB +: SW] = stat_q;
            mem_wdata[SZW-1:0]  = written;
         end
         default: ;
      endcase
   end

   // R5
   frag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FWR) |-> (frag_len != '0) && (frag_len <= remaining));

   // R5
   size_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRD && mem_done && !rd_own) |-> rd_size[4:0] == 5'd0);

   // R3
   ptr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_load && state != ST_IDLE && state != ST_ADV) |=> $stable(cur_ptr));

endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
   import rxdesc_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SW       = 8,
   parameter int SZW      = 12,
   parameter int FCW      = 12,
   parameter int MAX_FRAG = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rx_en,
   input  logic           refresh,
   input  logic           ptr_load,
   input  logic [AW-1:0]  ptr_value,
   input  logic [FCW-1:0] fifo_avail,
   input  logic           fifo_eop,
   input  logic [SW-1:0]  fifo_status,
   output logic           fifo_take,
   output logic [SZW-1:0] fifo_take_len,
   input  logic           fifo_full,
   input  logic           fifo_push,
   output logic           mem_req,
   output logic [1:0]     mem_op,
   output logic [AW-1:0]  mem_addr,
   output logic [SZW-1:0] mem_len,
   output logic [31:0]    mem_wdata,
   input  logic [95:0]    mem_rdata,
   input  logic           mem_done,
   output logic           irq_rx_ovr
);

   generate
      if (AW < 8 || AW > WORD_W) begin : g_bad_aw
         $error("rxdesc_dma: AW must lie in 8..32");
      end
      if (SW < 1 || SW > 14) begin : g_bad_sw
         $error("rxdesc_dma: SW must lie in 1..14");
      end
      if (SZW < 6 || SZW > 16) begin : g_bad_szw
         $error("rxdesc_dma: SZW must lie in 6..16");
      end
      if (MAX_FRAG < 0 || MAX_FRAG >= (1 << SZW)) begin : g_bad_frag
         $error("rxdesc_dma: MAX_FRAG out of range");
      end
   endgenerate

   rx_state_e      state;
   logic           rd_own, link_nz, avail_nz, frag_last, frag_fills;

   rxdesc_fsm i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en),
      .refresh    (refresh),
      .mem_done   (mem_done),
      .rd_own     (rd_own),
      .link_nz    (link_nz),
      .avail_nz   (avail_nz),
      .frag_last  (frag_last),
      .frag_fills (frag_fills),
      .state      (state),
      .mem_req    (mem_req),
      .fifo_take  (fifo_take)
   );

   rxdesc_ctx #(
      .AW       (AW),
      .SW       (SW),
      .SZW      (SZW),
      .FCW      (FCW),
      .MAX_FRAG (MAX_FRAG)
   ) i_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .mem_done    (mem_done),
      .mem_rdata   (mem_rdata),
      .ptr_load    (ptr_load),
      .ptr_value   (ptr_value),
      .fifo_avail  (fifo_avail),
      .fifo_eop    (fifo_eop),
      .fifo_status (fifo_status),
      .mem_op      (mem_op),
      .mem_addr    (mem_addr),
      .mem_len     (mem_len),
      .mem_wdata   (mem_wdata),
      .rd_own      (rd_own),
      .link_nz     (link_nz),
      .avail_nz    (avail_nz),
      .frag_last   (frag_last),
      .frag_fills  (frag_fills),
      .frag_len    (fifo_take_len)
   );

   rxdesc_ovf i_ovf (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_full  (fifo_full),
      .fifo_push  (fifo_push),
      .irq_rx_ovr (irq_rx_ovr)
   );

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> mem_req && $stable(mem_addr) && $stable(mem_op));

endmodule

// File: tb/test_rxdesc_dma.sv
module test_rxdesc_dma;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        refresh, ptr_load, fifo_eop, fifo_full, fifo_push, mem_done;
   logic [31:0] ptr_value;
   logic [11:0] fifo_avail;
   logic [7:0]  fifo_status;
   logic        fifo_take, mem_req, irq_rx_ovr, rx_en;
   logic [11:0] fifo_take_len, mem_len;
   logic [1:0]  mem_op;
   logic [31:0] mem_addr, mem_wdata;
   logic [95:0] mem_rdata;

   int nchk = 0, nbad = 0;
   int served = 0, stops_seen = 0, stops_allowed = 0;
   int pushed = 0, taken = 0;
   logic en_run;

   typedef struct {
      logic [1:0]  op;
      logic [31:0] addr;
      int          len;
      logic [31:0] wdata;
      bit          stop;
      string       tag;
   } exp_t;

   exp_t        sbq[$];
   logic [31:0] mem [int unsigned];

   always #4 clk = ~clk;

   assign rx_en      = en_run && (stops_seen < stops_allowed);
   assign fifo_avail = 12'(pushed - taken);

   always @(posedge clk) if (fifo_take) taken <= taken + int'(fifo_take_len);

   rxdesc_dma i_rxdesc_dma (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .refresh(refresh),
      .ptr_load(ptr_load), .ptr_value(ptr_value),
      .fifo_avail(fifo_avail), .fifo_eop(fifo_eop), .fifo_status(fifo_status),
      .fifo_take(fifo_take), .fifo_take_len(fifo_take_len),
      .fifo_full(fifo_full), .fifo_push(fifo_push),
      .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_len(mem_len),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done),
      .irq_rx_ovr(irq_rx_ovr)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic expect_tx(input logic [1:0] op, input logic [31:0] addr,
                            input int len, input logic [31:0] wdata,
                            input bit stop, input string tag);
      exp_t e;
      e.op = op; e.addr = addr; e.len = len; e.wdata = wdata;
      e.stop = stop; e.tag = tag;
      sbq.push_back(e);
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'h0;
   endfunction

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   endtask

   // monitor: memory responder and scoreboard comparison
   initial begin
      mem_done  = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_req) begin
            exp_t        e;
            logic [1:0]  op;
            logic [31:0] a, wd;
            int          len, lat;
            bit          stop;
            op = mem_op; a = mem_addr; len = int'(mem_len); wd = mem_wdata;
            stop = 1'b0;
            if (sbq.size() == 0) begin
               check(1'b0, "R4", "unexpected request", a, 32'h0);
            end else begin
               e = sbq.pop_front();
               check(op == e.op, e.tag, "op", 32'(op), 32'(e.op));
               check(a == e.addr, e.tag, "addr", a, e.addr);
               if (e.op == 2'd1) check(len == e.len, e.tag, "len", 32'(len), 32'(e.len));
               if (e.op == 2'd2) check(wd == e.wdata, e.tag, "wdata", wd, e.wdata);
               stop = e.stop;
            end
            lat = 1 + (served % 3);
            for (int k = 0; k < lat; k++) begin
               @(negedge clk);
               check(mem_req && mem_addr == a && mem_op == op, "R10", "request held",
                     mem_addr, a);
            end
            if (op == 2'd0 || op == 2'd3) mem_rdata = {rd(a + 8), rd(a + 4), rd(a)};
            if (op == 2'd2) mem[a] = wd;
            mem_done = 1'b1;
            served++;
            if (stop) stops_seen++;
            @(negedge clk);
            mem_done = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int base;
      rst_n = 1'b0; en_run = 1'b0; refresh = 1'b0; ptr_load = 1'b0; ptr_value = '0;
      fifo_eop = 1'b0; fifo_status = '0; fifo_full = 1'b0; fifo_push = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 0);
      check(!fifo_take, "R1", "fifo_take after reset", 32'(fifo_take), 0);
      check(!irq_rx_ovr, "R1", "irq after reset", 32'(irq_rx_ovr), 0);

      mem[32'h100] = 32'h200; mem[32'h104] = 32'd64;  mem[32'h108] = 32'h1000;
      mem[32'h200] = 32'h300; mem[32'h204] = 32'd32;  mem[32'h208] = 32'h2000;
      mem[32'h300] = 32'h0;   mem[32'h304] = 32'd96;  mem[32'h308] = 32'h3000;
      mem[32'h400] = 32'h500; mem[32'h404] = 32'h0;   mem[32'h408] = 32'h0;
      mem[32'h500] = 32'h0;   mem[32'h504] = 32'd160; mem[32'h508] = 32'h5000;

      // chained frame of 100 bytes over three buffers
      ptr_load = 1'b1; ptr_value = 32'h100;
      @(negedge clk);
      ptr_load = 1'b0;
      expect_tx(2'd0, 32'h100, 0, 0, 0, "R2");
      expect_tx(2'd1, 32'h1000, 20, 0, 0, "R5");
      expect_tx(2'd1, 32'h1014, 44, 0, 0, "R5");
      expect_tx(2'd2, 32'h104, 0, 32'hC000_0040, 0, "R7");
      expect_tx(2'd0, 32'h200, 0, 0, 0, "R8");
      expect_tx(2'd1, 32'h2000, 32, 0, 0, "R5");
      expect_tx(2'd2, 32'h204, 0, 32'hC000_0020, 0, "R7");
      expect_tx(2'd0, 32'h300, 0, 0, 0, "R8");
      expect_tx(2'd1, 32'h3000, 4, 0, 0, "R5");
      expect_tx(2'd2, 32'h304, 0, 32'h805A_0004, 0, "R6");
      expect_tx(2'd0, 32'h300, 0, 0, 1, "R4");
      fifo_status = 8'h5A;
      en_run = 1'b1; stops_allowed = 1;
      wait (served >= 1);
      @(negedge clk);
      // R3: load while busy must not move the status write away from 0x104
      ptr_load = 1'b1; ptr_value = 32'h900;
      @(negedge clk);
      ptr_load = 1'b0;
      pushed = 20;
      wait (taken == 20);
      @(negedge clk);
      pushed = 100; fifo_eop = 1'b1;
      wait (stops_seen == 1);
      repeat (20) @(negedge clk);
      check(sbq.size() == 0, "R8", "queue drained", 32'(sbq.size()), 0);
      check(!mem_req, "R4", "no request after owned read", 32'(mem_req), 0);
      check(taken == 100, "R5", "bytes taken frame 1", 32'(taken), 32'd100);

      // refresh path, frame of 150 bytes split by the burst cap
      ptr_load = 1'b1; ptr_value = 32'h400;
      @(negedge clk);
      ptr_load = 1'b0;
      expect_tx(2'd3, 32'h400, 0, 0, 0, "R9");
      expect_tx(2'd0, 32'h500, 0, 0, 0, "R9");
      expect_tx(2'd1, 32'h5000, 64, 0, 0, "R5");
      expect_tx(2'd1, 32'h5040, 64, 0, 0, "R5");
      expect_tx(2'd1, 32'h5080, 22, 0, 0, "R5");
      expect_tx(2'd2, 32'h504, 0, 32'h8033_0096, 0, "R6");
      expect_tx(2'd0, 32'h500, 0, 0, 1, "R4");
      base = served;
      fifo_status = 8'h33; fifo_eop = 1'b1; pushed = 250; refresh = 1'b1;
      stops_allowed = 2;
      wait (served >= base + 1);
      @(negedge clk);
      refresh = 1'b0;
      wait (stops_seen == 2);
      repeat (20) @(negedge clk);
      check(sbq.size() == 0, "R9", "queue drained", 32'(sbq.size()), 0);
      check(!mem_req, "R4", "idle after owned read", 32'(mem_req), 0);
      check(taken == 250, "R5", "bytes taken frame 2", 32'(taken), 32'd250);

      // R11 overflow interrupt
      fifo_full = 1'b1;
      @(negedge clk);
      check(!irq_rx_ovr, "R11", "full without push", 32'(irq_rx_ovr), 0);
      fifo_push = 1'b1;
      @(negedge clk);
      check(irq_rx_ovr, "R11", "push while full", 32'(irq_rx_ovr), 1);
      fifo_push = 1'b0;
      @(negedge clk);
      check(!irq_rx_ovr, "R11", "pulse ends", 32'(irq_rx_ovr), 0);
      fifo_full = 1'b0; fifo_push = 1'b1;
      @(negedge clk);
      check(!irq_rx_ovr, "R11", "push while not full", 32'(irq_rx_ovr), 0);
      fifo_push = 1'b0;
      finish_run();
   end

endmodule